// File: doc/BRIEF.md
# Multi-Channel ADC Scan Sequencer

This block is the digital controller around an analog-to-digital conversion core. A trigger starts a scan over an inclusive range of up to eight input channels, from a programmable first channel to a programmable last channel. A software write or a hardware pulse can be the trigger. For each channel the block sends a one-cycle start pulse with the channel number to the core. It waits for the core's done pulse, latches the result and moves to the next channel. When the last channel is lower than the first, the channel number wraps from 7 back to 0.

Each 10-bit result sits in one register. Software reads it as two byte locations: a 2-bit high part and an 8-bit low part. A completion flag, a sticky overwrite-error flag and an interrupt flag report each result, and an output shows the channel being converted. One busy bit serves as both the software start control and the status bit. In single-pass mode the busy bit clears after one sweep. In continuous mode sweeps repeat until software writes 0 to the busy bit. Writing 0 to the busy bit, or dropping the enable input, aborts the conversion in progress and discards its result.

Top module: `adc_scan_seq`

## Requirements
- R1: After a trigger, the channel sent with the first start pulse equals the first-channel setting. Each later start pulse carries the next channel number, up to and including the last-channel setting, so every channel in the range is converted once per sweep.
- R2: When the last-channel setting is below the first-channel setting, the sequence runs from the first channel up to 7, wraps to 0 and ends at the last channel.
- R3: On each accepted done pulse, the 10-bit result is latched. Bits 9:8 appear on `res_hi[1:0]` and bits 7:0 on `res_lo[7:0]`. The completion flag and the interrupt flag are both 1 after that clock edge.
- R4: `busy` reads 1 from the clock edge that takes a trigger until the sweep ends or is aborted. This holds for a software start (write strobe with value 1) and for a hardware trigger pulse alike.
- R5: `cur_ch` equals the channel number on `core_ch` for the conversion in progress.
- R6: A result accepted while the completion flag is 1 sets the overwrite-error flag, and the new result replaces the old one. A result accepted while the completion flag is 0 leaves the overwrite-error flag unchanged.
- R7: A read strobe on the low result byte clears the completion flag. Only the overwrite-clear strobe clears the overwrite-error flag, and only the interrupt-clear strobe clears the interrupt flag.
- R8: In single-pass mode (`cfg_single` = 1), `busy` is 0 after the clock edge that accepts the last channel's result.
- R9: In continuous mode (`cfg_single` = 0), the block returns to the first channel after the last one, and `busy` stays 1 until it is stopped.
- R10: A software write of 0 to the busy bit clears `busy` at that clock edge and produces a one-cycle `core_abort` in the next cycle. A done pulse in the stop cycle or later leaves the result and the flags unchanged.
- R11: Driving `cfg_en` low while busy has the same effect as a stop write: `busy` clears, `core_abort` pulses, and no result is taken.
- R12: Triggers are ignored while `busy` is 1 or while `cfg_en` is 0. The channel in progress does not change and no new start pulse is issued.
- R13: When a flag set and a clear strobe for the same flag fall in the same cycle, the set wins.
- R14: After reset, `busy`, all three flags, `core_start`, `core_abort` and the result bytes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Converter enable; low aborts and blocks triggers |
| cfg_single | input | 1 | 1 = single sweep, 0 = continuous sweeps |
| cfg_first | input | 3 | First channel of the scan range |
| cfg_last | input | 3 | Last channel of the scan range |
| sw_start_wr | input | 1 | Write strobe for the busy/start bit |
| sw_start_val | input | 1 | Value written with `sw_start_wr` (1 start, 0 stop) |
| hw_trig | input | 1 | Hardware trigger pulse |
| rd_lo_stb | input | 1 | Read strobe of the low result byte |
| clr_ovr_wr | input | 1 | Clear strobe for the overwrite-error flag |
| clr_irq_wr | input | 1 | Clear strobe for the interrupt flag |
| core_start | output | 1 | One-cycle start pulse to the core |
| core_ch | output | 3 | Channel number for the core |
| core_abort | output | 1 | One-cycle abort pulse to the core |
| core_done | input | 1 | Core conversion done pulse |
| core_data | input | 10 | Core result, valid with `core_done` |
| busy | output | 1 | Busy/start status bit |
| cur_ch | output | 3 | Channel being converted |
| res_hi | output | 2 | Result bits 9:8 |
| res_lo | output | 8 | Result bits 7:0 |
| cmpl_flag | output | 1 | Conversion-complete flag |
| ovr_flag | output | 1 | Sticky overwrite-error flag |
| irq_flag | output | 1 | Interrupt flag |

## Verification
The assertions assume that the core raises `core_done` only for a conversion it was started on and did not abort, and never in the same cycle as the start pulse. They also assume that the range settings are held stable during a sweep, since the single-pass end check compares against the live last-channel setting. The bench's core model answers a fixed number of cycles after each start, clears itself on an abort, and the bench changes the range settings only while the block is idle. The one exception is the busy-write test, which changes the first-channel setting on purpose and checks that the running sweep ignores it.

// File: rtl/adc_scan_pkg.sv
// Package adc_scan_pkg
// Shared sizes for the scan sequencer. It assumes at most eight channels
// and a result width of at least nine bits, so the high byte is not empty.
package adc_scan_pkg;
    localparam int N_CH  = 8;
    localparam int RES_W = 10;
    localparam int CH_W  = $clog2(N_CH);
    localparam int HI_W  = RES_W - 8;
endpackage

// File: rtl/adc_scan_ctrl.sv
// Module adc_scan_ctrl
// Channel sequencer: holds the busy bit, walks the channel counter from the
// first to the last channel (wrapping at N_CH-1), issues start and abort
// pulses, and reports which done pulses count as results.
// Assumes the core raises done only for an unaborted conversion that it was
// started on, and that the range settings stay stable during a sweep.
module adc_scan_ctrl #(
    parameter int N_CH = 8,
    parameter int CH_W = $clog2(N_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_en,
    input  logic            cfg_single,
    input  logic [CH_W-1:0] cfg_first,
    input  logic [CH_W-1:0] cfg_last,
    input  logic            sw_start_wr,
    input  logic            sw_start_val,
    input  logic            hw_trig,
    input  logic            core_done,
    output logic            core_start,
    output logic            core_abort,
    output logic            busy,
    output logic [CH_W-1:0] cur_ch,
    output logic            accept
);
    localparam logic [CH_W-1:0] TOP_CH = CH_W'(N_CH - 1);

    logic            launch_q;
    logic            abort_q;
    logic [CH_W-1:0] ch_q;
    logic            trig;
    logic            stop_req;
    logic            last_hit;
    logic [CH_W-1:0] ch_next;

    // Decode triggers, stop requests, accepted results and the next channel.
    always_comb begin
        trig     = (sw_start_wr && sw_start_val) || hw_trig;
        stop_req = busy && (!cfg_en || (sw_start_wr && !sw_start_val));
        accept   = busy && !launch_q && core_done && !stop_req;
        last_hit = (ch_q == cfg_last);
        ch_next  = (ch_q == TOP_CH) ? '0 : ch_q + 1'b1;
    end

    // Sequencer state: busy bit, channel counter, start and abort pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            ch_q     <= '0;
            launch_q <= 1'b0;
            abort_q  <= 1'b0;
        end else begin
            launch_q <= 1'b0;
            abort_q  <= 1'b0;
            if (stop_req) begin
                busy    <= 1'b0;
                abort_q <= 1'b1;
            end else if (!busy) begin
                if (trig && cfg_en) begin
                    busy     <= 1'b1;
                    ch_q     <= cfg_first;
                    launch_q <= 1'b1;
                end
            end else if (accept) begin
                if (last_hit && cfg_single) begin
                    busy <= 1'b0;
                end else begin
                    ch_q     <= last_hit ? cfg_first : ch_next;
                    launch_q <= 1'b1;
                end
            end
        end
    end

    // Drive the outputs from the registered state.
    always_comb begin
        core_start = launch_q;
        core_abort = abort_q;
        cur_ch     = ch_q;
    end

    AST_START_AT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (cur_ch == $past(cfg_first)));                 // R1
    AST_ABORT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        core_abort |-> !busy);                                         // R10
    AST_SINGLE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (cur_ch == cfg_last) && cfg_single) |=> !busy);     // R8
    AST_CONT_KEEPS_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cfg_single) |=> busy);                             // R9
    AST_DISABLED_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cfg_en) |=> !busy);                                 // R12
endmodule

// File: rtl/adc_result_reg.sv
// Module adc_result_reg
// Result register and status flags. Latches each accepted result, sets the
// completion and interrupt flags, and raises the sticky overwrite-error flag
// when a result arrives before the previous one was read. A set in the same
// cycle as a clear wins.
module adc_result_reg #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [RES_W-1:0] core_data,
    input  logic             rd_lo_stb,
    input  logic             clr_ovr_wr,
    input  logic             clr_irq_wr,
    output logic [RES_W-1:0] result,
    output logic             cmpl_flag,
    output logic             ovr_flag,
    output logic             irq_flag
);
    // Result data register, loaded only by accepted done pulses.
    always_ff @(posedge clk) begin
        if (!rst_n)      result <= '0;
        else if (accept) result <= core_data;
    end

    // Flag registers: set by a result, cleared by their own strobe, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmpl_flag <= 1'b0;
            ovr_flag  <= 1'b0;
            irq_flag  <= 1'b0;
        end else begin
            cmpl_flag <= accept ? 1'b1 : (rd_lo_stb ? 1'b0 : cmpl_flag);
            ovr_flag  <= (accept && cmpl_flag) ? 1'b1 : (clr_ovr_wr ? 1'b0 : ovr_flag);
            irq_flag  <= accept ? 1'b1 : (clr_irq_wr ? 1'b0 : irq_flag);
        end
    end

    AST_RESULT_SETS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (cmpl_flag && irq_flag));                           // R3
    AST_OVERWRITE_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmpl_flag) |=> ovr_flag);                           // R6
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !clr_ovr_wr) |=> ovr_flag);                       // R7
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !clr_irq_wr) |=> irq_flag);                       // R7
    AST_CMPL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_flag && !rd_lo_stb) |=> cmpl_flag);                      // R7
endmodule

// File: rtl/adc_scan_seq.sv
// Module adc_scan_seq
// Top of the multi-channel scan sequencer: joins the channel sequencer and
// the result/flag register and splits the result into two byte views.
// Assumes a converter core with a start/abort/done handshake.
module adc_scan_seq
    import adc_scan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_single,
    input  logic [CH_W-1:0]  cfg_first,
    input  logic [CH_W-1:0]  cfg_last,
    input  logic             sw_start_wr,
    input  logic             sw_start_val,
    input  logic             hw_trig,
    input  logic             rd_lo_stb,
    input  logic             clr_ovr_wr,
    input  logic             clr_irq_wr,
    output logic             core_start,
    output logic [CH_W-1:0]  core_ch,
    output logic             core_abort,
    input  logic             core_done,
    input  logic [RES_W-1:0] core_data,
    output logic             busy,
    output logic [CH_W-1:0]  cur_ch,
    output logic [HI_W-1:0]  res_hi,
    output logic [7:0]       res_lo,
    output logic             cmpl_flag,
    output logic             ovr_flag,
    output logic             irq_flag
);
    logic             accept;
    logic [RES_W-1:0] result;

    adc_scan_ctrl #(.N_CH(N_CH), .CH_W(CH_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_single(cfg_single),
        .cfg_first(cfg_first), .cfg_last(cfg_last),
        .sw_start_wr(sw_start_wr), .sw_start_val(sw_start_val),
        .hw_trig(hw_trig), .core_done(core_done),
        .core_start(core_start), .core_abort(core_abort),
        .busy(busy), .cur_ch(cur_ch), .accept(accept)
    );

    adc_result_reg #(.RES_W(RES_W)) res_i (
        .clk(clk), .rst_n(rst_n), .accept(accept), .core_data(core_data),
        .rd_lo_stb(rd_lo_stb), .clr_ovr_wr(clr_ovr_wr), .clr_irq_wr(clr_irq_wr),
        .result(result), .cmpl_flag(cmpl_flag), .ovr_flag(ovr_flag),
        .irq_flag(irq_flag)
    );

    // Byte views of the result and the channel sent to the core.
    always_comb begin
        res_hi  = result[RES_W-1:8];
        res_lo  = result[7:0];
        core_ch = cur_ch;
    end
endmodule

// File: tb/adc_scan_seq_tb_top.sv
// Directed bench for adc_scan_seq with a fixed-latency converter model.
module adc_scan_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en = 1'b1, cfg_single = 1'b1;
    logic [2:0] cfg_first = '0, cfg_last = '0;
    logic sw_start_wr = 1'b0, sw_start_val = 1'b0, hw_trig = 1'b0;
    logic rd_man = 1'b0, rd_auto = 1'b0, auto_read = 1'b0;
    logic clr_ovr_wr = 1'b0, clr_irq_wr = 1'b0;
    logic core_start, core_abort, core_done = 1'b0;
    logic [2:0] core_ch;
    logic [9:0] core_data = '0;
    logic busy, cmpl_flag, ovr_flag, irq_flag;
    logic [2:0] cur_ch;
    logic [1:0] res_hi;
    logic [7:0] res_lo;
    logic rd_lo_stb;

    int checks = 0, fails = 0, n_res = 0;

    assign rd_lo_stb = rd_man | rd_auto;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_scan_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_single(cfg_single),
        .cfg_first(cfg_first), .cfg_last(cfg_last),
        .sw_start_wr(sw_start_wr), .sw_start_val(sw_start_val), .hw_trig(hw_trig),
        .rd_lo_stb(rd_lo_stb), .clr_ovr_wr(clr_ovr_wr), .clr_irq_wr(clr_irq_wr),
        .core_start(core_start), .core_ch(core_ch), .core_abort(core_abort),
        .core_done(core_done), .core_data(core_data),
        .busy(busy), .cur_ch(cur_ch), .res_hi(res_hi), .res_lo(res_lo),
        .cmpl_flag(cmpl_flag), .ovr_flag(ovr_flag), .irq_flag(irq_flag)
    );

    // Expected result pattern for a channel.
    function automatic logic [9:0] pat(input logic [2:0] ch);
        return {ch, ~ch, ch, 1'b1};
    endfunction

    // Converter model: answers LAT+1 cycles after a start, cleared by abort.
    logic [3:0] lat_cnt = '0;
    logic       pend = 1'b0;
    logic [2:0] ch_l = '0;
    always @(posedge clk) begin
        core_done <= 1'b0;
        if (!rst_n || core_abort) pend <= 1'b0;
        else if (core_start) begin
            pend <= 1'b1; lat_cnt <= 4'(LAT); ch_l <= core_ch;
        end else if (pend) begin
            if (lat_cnt == 0) begin
                core_done <= 1'b1; core_data <= pat(ch_l); pend <= 1'b0;
            end else lat_cnt <= lat_cnt - 1'b1;
        end
    end

    // Automatic reader of the low byte, and a count of results seen.
    always @(negedge clk) begin
        rd_auto <= auto_read && cmpl_flag;
        if (auto_read && cmpl_flag && !rd_auto) n_res++;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic sw_write(input logic v);
        sw_start_wr = 1'b1; sw_start_val = v;
        @(negedge clk);
        sw_start_wr = 1'b0; sw_start_val = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic clear_flags();
        rd_man = 1'b1; clr_ovr_wr = 1'b1; clr_irq_wr = 1'b1;
        @(negedge clk);
        rd_man = 1'b0; clr_ovr_wr = 1'b0; clr_irq_wr = 1'b0;
        @(negedge clk);
    endtask

    // R14: reset state.
    task automatic t_reset();
        check(busy == 0 && cmpl_flag == 0 && ovr_flag == 0 && irq_flag == 0,
              "R14", "flags/busy after reset", {busy, cmpl_flag, ovr_flag, irq_flag}, 0);
        check(core_start == 0 && core_abort == 0 && res_lo == 0 && res_hi == 0,
              "R14", "handshake/result after reset", {core_start, core_abort, res_hi, res_lo}, 0);
    endtask

    // R1/R2/R3/R4/R5/R8: single sweep, with each channel and result checked.
    task automatic t_sweep(input logic [2:0] first, input logic [2:0] last, input string req);
        logic [2:0] ch;
        cfg_first = first; cfg_last = last; cfg_single = 1'b1; auto_read = 1'b1;
        @(negedge clk);
        sw_write(1'b1);
        ch = first;
        forever begin
            while (!core_start) @(negedge clk);
            check(core_ch == ch, req, "start channel", core_ch, ch);
            check(cur_ch == ch && busy, "R5", "cur_ch during conversion", cur_ch, ch);
            @(negedge clk);
            while (!cmpl_flag) @(negedge clk);
            check({res_hi, res_lo} == pat(ch) && irq_flag, "R3", "result bytes",
                  {res_hi, res_lo}, pat(ch));
            if (ch == last) break;
            ch = ch + 1'b1;
        end
        check(busy == 0, "R8", "busy after single sweep", busy, 0);
        repeat (3) @(negedge clk);
        auto_read = 1'b0;
        clear_flags();
    endtask

    // R4: hardware trigger sets busy.
    task automatic t_hw_trig();
        cfg_first = 3'd3; cfg_last = 3'd3; cfg_single = 1'b1;
        hw_trig = 1'b1;
        @(negedge clk);
        hw_trig = 1'b0;
        check(busy == 1 && cur_ch == 3, "R4", "busy after hw trigger", busy, 1);
        wait_idle();
        check(cmpl_flag == 1 && {res_hi, res_lo} == pat(3), "R4", "hw result",
              {res_hi, res_lo}, pat(3));
        clear_flags();
    endtask

    // R6/R7: overwrite detection and flag clearing rules.
    task automatic t_overwrite();
        cfg_first = 3'd0; cfg_last = 3'd1; cfg_single = 1'b1; auto_read = 1'b0;
        sw_write(1'b1);
        wait_idle();
        check(ovr_flag == 1 && cmpl_flag == 1, "R6", "overwrite flag set", ovr_flag, 1);
        check({res_hi, res_lo} == pat(1), "R6", "new data replaces old", {res_hi, res_lo}, pat(1));
        rd_man = 1'b1; @(negedge clk); rd_man = 1'b0;
        check(cmpl_flag == 0 && ovr_flag == 1 && irq_flag == 1, "R7", "read clears only cmpl",
              {cmpl_flag, ovr_flag, irq_flag}, 3);
        clr_ovr_wr = 1'b1; @(negedge clk); clr_ovr_wr = 1'b0;
        check(ovr_flag == 0 && irq_flag == 1, "R7", "ovr clear", {ovr_flag, irq_flag}, 1);
        clr_irq_wr = 1'b1; @(negedge clk); clr_irq_wr = 1'b0;
        check(irq_flag == 0, "R7", "irq clear", irq_flag, 0);
        cfg_first = 3'd4; cfg_last = 3'd4;
        sw_write(1'b1);
        wait_idle();
        check(ovr_flag == 0 && cmpl_flag == 1, "R6", "no overwrite when cmpl was 0", ovr_flag, 0);
        clear_flags();
    endtask

    // R9/R10: continuous mode runs until a stop write aborts it.
    task automatic t_continuous();
        int snap;
        cfg_first = 3'd3; cfg_last = 3'd4; cfg_single = 1'b0; auto_read = 1'b1;
        n_res = 0;
        sw_write(1'b1);
        while (n_res < 5) @(negedge clk);
        check(busy == 1, "R9", "still busy after 5 results", busy, 1);
        sw_start_wr = 1'b1; sw_start_val = 1'b0;
        @(negedge clk);
        sw_start_wr = 1'b0;
        check(busy == 0 && core_abort == 1, "R10", "stop clears busy, aborts",
              {busy, core_abort}, 1);
        snap = n_res;
        repeat (30) @(negedge clk);
        check(n_res == snap && cmpl_flag == 0, "R10", "no result after stop", n_res, snap);
        auto_read = 1'b0; cfg_single = 1'b1;
        clear_flags();
    endtask

    // R11: dropping enable aborts.
    task automatic t_disable();
        cfg_first = 3'd0; cfg_last = 3'd7; cfg_single = 1'b1;
        sw_write(1'b1);
        while (!core_start) @(negedge clk);
        repeat (2) @(negedge clk);
        cfg_en = 1'b0;
        @(negedge clk);
        check(busy == 0 && core_abort == 1, "R11", "enable low aborts", {busy, core_abort}, 1);
        repeat (30) @(negedge clk);
        check(cmpl_flag == 0 && irq_flag == 0, "R11", "no flag after disable",
              {cmpl_flag, irq_flag}, 0);
    endtask

    // R12: triggers ignored while disabled or busy.
    task automatic t_ignore();
        hw_trig = 1'b1; @(negedge clk); hw_trig = 1'b0;
        check(busy == 0, "R12", "trigger ignored when disabled", busy, 0);
        cfg_en = 1'b1;
        cfg_first = 3'd2; cfg_last = 3'd3; auto_read = 1'b1;
        @(negedge clk);
        sw_write(1'b1);
        while (!core_start) @(negedge clk);
        cfg_first = 3'd5;
        sw_write(1'b1);
        check(cur_ch == 2 && core_start == 0 && busy == 1, "R12", "start while busy ignored",
              cur_ch, 2);
        cfg_first = 3'd2;
        wait_idle();
        auto_read = 1'b0;
        clear_flags();
    endtask

    // R13: set beats clear in the same cycle.
    task automatic t_priority();
        cfg_first = 3'd5; cfg_last = 3'd5; cfg_single = 1'b1;
        sw_write(1'b1);
        while (!core_done) @(negedge clk);
        rd_man = 1'b1; clr_irq_wr = 1'b1;
        @(negedge clk);
        rd_man = 1'b0; clr_irq_wr = 1'b0;
        check(cmpl_flag == 1 && irq_flag == 1, "R13", "set wins over clear",
              {cmpl_flag, irq_flag}, 3);
        clear_flags();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sweep(3'd2, 3'd5, "R1");
        t_sweep(3'd6, 3'd1, "R2");
        t_hw_trig();
        t_overwrite();
        t_continuous();
        t_disable();
        t_ignore();
        t_priority();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule